// File: doc/BRIEF.md
# ADC Single-Step Sample Sequencer Controller

This block sits between a processor bus and an analog-to-digital converter and runs a sequence that has exactly one sample step. Software configures it through a small register slave port: it selects the analog channel, sets a four-bit control nibble for the step, picks the trigger source and finally enables the sequencer. A trigger then raises a request to the converter. That request carries the channel number, a differential flag and a temperature-sensor select, and it is held until the converter answers with a done pulse and a 12-bit result.

On completion the result enters a one-entry result FIFO. If the step's interrupt-enable bit was set, a sticky raw status bit is also raised and drives the interrupt output. Software reads the result, which pops it, and clears the status bit by writing a one to it. While the sequencer is disabled every trigger is ignored, so it can be reconfigured without risk. A four-sequencer priority word is kept only for read-back.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `conv_req` and `irq` are 0, and every readable register returns 0: enable (0x000), raw status (0x004), trigger select (0x014) and priority (0x020).
- R2: Bit 3 of the enable register (0x000) turns the sequencer on. While it is 0, processor initiates and external triggers are ignored and `conv_req` stays 0.
- R3: The trigger-select field is bits 15:12 of 0x014. Value 0 means a write with bit 3 set to the initiate register (0x028) starts a sequence. Value 1 means `ext_trig` high at a clock edge starts one. Any other value never starts a sequence, and a trigger of the kind that is not selected is ignored.
- R4: `conv_req` rises in the cycle after the trigger edge. While it is high, `conv_chan` holds bits 3:0 of the input mux register (0x0A0), `conv_diff` holds control-nibble bit 0 and `conv_temp` holds control-nibble bit 3 (nibble at 0x0A4 bits 3:0), all captured at the trigger and held stable until `conv_done`.
- R5: A trigger that arrives while a conversion is in flight is ignored. After `conv_done` the request falls and no second conversion starts.
- R6: When a conversion completes and control-nibble bit 2 was set, bit 3 of 0x004 (also readable at 0x00C) and `irq` become 1 and stay 1. With bit 2 clear they stay 0. The end bit (nibble bit 1) has no effect, because the single step always ends the sequence.
- R7: Writing 1 to bit 3 of 0x00C clears the raw status bit, and writing 0 there has no effect. If a completion that sets the bit falls in the same cycle as the clear, the bit ends up set.
- R8: A read of 0x0A8 returns the 12-bit result in bits 11:0 and empties the FIFO. A read while it is empty returns 0 and sets a sticky underflow flag at bit 9 of 0x004.
- R9: A completion while the FIFO is full replaces the stored result and sets a sticky overflow flag at bit 8 of 0x004. Writing 1 to bit 8 or bit 9 of 0x00C clears the matching flag.
- R10: The priority register (0x020) stores bits 15:0 as written and reads them back with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the FIFO at 0x0A8) |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ext_trig | input | 1 | External trigger, sampled at clock edges |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 4 | Channel to convert |
| conv_diff | output | 1 | Differential mode select |
| conv_temp | output | 1 | Temperature-sensor select |
| conv_done | input | 1 | Single-cycle conversion-complete pulse |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |
| irq | output | 1 | Interrupt, follows the raw status bit |

## Verification
The converter's completion can set the raw status bit in the same clock edge in which software writes one to clear it. The bench arranges this by raising `conv_done` and a clear write to 0x00C in the same bus cycle for a step that has its interrupt-enable bit set. It then reads 0x004 and expects bit 3 to be 1, since the set must win over the clear. A clear issued on its own must then return the bit to 0.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 12,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [11:0]      addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             ext_trig,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_diff,
  output logic             conv_temp,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             irq
);

  localparam logic [11:0] A_EN   = 12'h000;
  localparam logic [11:0] A_RAW  = 12'h004;
  localparam logic [11:0] A_CLR  = 12'h00C;
  localparam logic [11:0] A_TSEL = 12'h014;
  localparam logic [11:0] A_PRI  = 12'h020;
  localparam logic [11:0] A_INIT = 12'h028;
  localparam logic [11:0] A_MUX  = 12'h0A0;
  localparam logic [11:0] A_CTL  = 12'h0A4;
  localparam logic [11:0] A_FIFO = 12'h0A8;

  logic             en_q, busy_q, raw_q, ovf_q, unf_q, full_q;
  logic [3:0]       tsel_q, ctl_q, run_ctl_q;
  logic [15:0]      pri_q;
  logic [CH_W-1:0]  mux_q, run_chan_q;
  logic [RES_W-1:0] fdata_q;

  logic sw_go, hw_go, start, done_ev, pop, clr_wr;

  assign sw_go   = wr_en && addr == A_INIT && wdata[3] && tsel_q == 4'd0;
  assign hw_go   = ext_trig && tsel_q == 4'd1;
  assign start   = en_q && !busy_q && (sw_go || hw_go);
  assign done_ev = busy_q && conv_done;
  assign pop     = rd_en && addr == A_FIFO;
  assign clr_wr  = wr_en && addr == A_CLR;

  assign conv_req  = busy_q;
  assign conv_chan = run_chan_q;
  assign conv_diff = run_ctl_q[0];
  assign conv_temp = run_ctl_q[3];
  assign irq       = raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; busy_q <= 1'b0; raw_q <= 1'b0; ovf_q <= 1'b0;
      unf_q <= 1'b0; full_q <= 1'b0; tsel_q <= '0; ctl_q <= '0;
      run_ctl_q <= '0; pri_q <= '0; mux_q <= '0; run_chan_q <= '0;
      fdata_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_EN:    en_q   <= wdata[3];
          A_TSEL:  tsel_q <= wdata[15:12];
          A_PRI:   pri_q  <= wdata[15:0];
          A_MUX:   mux_q  <= wdata[CH_W-1:0];
          A_CTL:   ctl_q  <= wdata[3:0];
          default: ;
        endcase
      end

      if (start) begin
        busy_q     <= 1'b1;
        run_chan_q <= mux_q;
        run_ctl_q  <= ctl_q;
      end else if (done_ev) begin
        busy_q <= 1'b0;
      end

      if (done_ev && run_ctl_q[2]) raw_q <= 1'b1;
      else if (clr_wr && wdata[3]) raw_q <= 1'b0;

      if (done_ev && full_q && !pop) ovf_q <= 1'b1;
      else if (clr_wr && wdata[8])   ovf_q <= 1'b0;

      if (pop && !full_q)           unf_q <= 1'b1;
      else if (clr_wr && wdata[9])  unf_q <= 1'b0;

      if (done_ev) begin
        fdata_q <= conv_result;
        full_q  <= 1'b1;
      end else if (pop) begin
        full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN:   rdata[3] = en_q;
      A_RAW:  begin rdata[3] = raw_q; rdata[8] = ovf_q; rdata[9] = unf_q; end
      A_CLR:  rdata[3] = raw_q;
      A_TSEL: rdata[15:12] = tsel_q;
      A_PRI:  rdata[15:0] = pri_q;
      A_MUX:  rdata[CH_W-1:0] = mux_q;
      A_CTL:  rdata[3:0] = ctl_q;
      A_FIFO: rdata[RES_W-1:0] = full_q ? fdata_q : '0;
      default: ;
    endcase
  end

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_req && !en_q |=> !conv_req);

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(conv_chan) && $stable(conv_diff) && $stable(conv_temp));

  // R6
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done && run_ctl_q[2] |=> irq);

  // R7
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_CLR && wdata[3] && !(conv_req && conv_done) |=> !irq);

  // R9
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done && full_q && !(rd_en && addr == A_FIFO) |=> ovf_q && full_q);

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ext_trig = 1'b0, conv_done = 1'b0;
  logic [11:0] addr = '0, conv_result = '0;
  logic [31:0] wdata = '0, rdata;
  logic conv_req, conv_diff, conv_temp, irq;
  logic [3:0] conv_chan;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_trig(ext_trig), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_diff(conv_diff), .conv_temp(conv_temp),
    .conv_done(conv_done), .conv_result(conv_result), .irq(irq));

  // chan[19:16] ctl[15:12] result[11:0]
  localparam logic [19:0] VEC [0:3] = '{
    {4'd1,  4'b0110, 12'hABC},
    {4'd11, 4'b1001, 12'h123},
    {4'd5,  4'b0100, 12'hFFF},
    {4'd0,  4'b1110, 12'h000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic complete(logic [11:0] r);
    @(negedge clk); conv_done = 1'b1; conv_result = r;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 conv_req", {31'b0, conv_req}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    bus_read(12'h000, d); check("R1 enable", d, 0);
    bus_read(12'h004, d); check("R1 raw", d, 0);
    bus_read(12'h014, d); check("R1 tsel", d, 0);
    bus_read(12'h020, d); check("R1 priority", d, 0);

    // R2 disabled: triggers ignored
    bus_write(12'h028, 32'h8);
    check("R2 initiate while off", {31'b0, conv_req}, 0);
    bus_write(12'h014, 32'h1000);
    pulse_ext();
    check("R2 ext while off", {31'b0, conv_req}, 0);
    bus_write(12'h014, 32'h0);

    // R10 priority read-back
    bus_write(12'h020, 32'hFFFF_0123);
    bus_read(12'h020, d); check("R10 priority", d, 32'h0123);

    bus_write(12'h000, 32'h8);
    bus_read(12'h000, d); check("R2 enable readback", d, 32'h8);

    for (int i = 0; i < 4; i++) begin
      logic [3:0] ch, ct; logic [11:0] res;
      {ch, ct, res} = VEC[i];
      bus_write(12'h0A0, {28'b0, ch});
      bus_write(12'h0A4, {28'b0, ct});
      bus_write(12'h028, 32'h8);
      check("R4 req", {31'b0, conv_req}, 1);
      check("R4 chan", {28'b0, conv_chan}, {28'b0, ch});
      check("R4 diff/temp", {30'b0, conv_temp, conv_diff}, {30'b0, ct[3], ct[0]});
      bus_write(12'h0A4, 32'h0);
      bus_write(12'h028, 32'h8);
      check("R4 held after ctl change", {30'b0, conv_temp, conv_diff}, {30'b0, ct[3], ct[0]});
      complete(res);
      check("R5 no restart", {31'b0, conv_req}, 0);
      bus_read(12'h004, d); check("R6 raw bit", d, {28'b0, ct[2], 3'b0});
      check("R6 irq", {31'b0, irq}, {31'b0, ct[2]});
      bus_read(12'h0A8, d); check("R8 fifo data", d, {20'b0, res});
      bus_write(12'h00C, 32'h0);
      bus_read(12'h00C, d); check("R7 write zero", d, {28'b0, ct[2], 3'b0});
      bus_write(12'h00C, 32'h8);
      bus_read(12'h004, d); check("R7 cleared", d, 0);
    end

    // R8 underflow
    bus_read(12'h0A8, d); check("R8 empty read", d, 0);
    bus_read(12'h004, d); check("R8 underflow flag", d, 32'h200);
    bus_write(12'h00C, 32'h200);
    bus_read(12'h004, d); check("R9 underflow cleared", d, 0);

    // R9 overflow
    bus_write(12'h0A4, 32'h2);
    bus_write(12'h028, 32'h8); complete(12'h111);
    bus_write(12'h028, 32'h8); complete(12'h222);
    bus_read(12'h004, d); check("R9 overflow flag", d, 32'h100);
    bus_read(12'h0A8, d); check("R9 overwrite", d, 32'h222);
    bus_write(12'h00C, 32'h100);
    bus_read(12'h004, d); check("R9 overflow cleared", d, 0);

    // R3 external trigger
    bus_write(12'h014, 32'h1000);
    bus_write(12'h028, 32'h8);
    check("R3 initiate ignored", {31'b0, conv_req}, 0);
    pulse_ext();
    check("R3 ext starts", {31'b0, conv_req}, 1);
    complete(12'h3C3);
    bus_read(12'h0A8, d); check("R3 ext result", d, 32'h3C3);
    bus_write(12'h014, 32'h2000);
    pulse_ext();
    bus_write(12'h028, 32'h8);
    check("R3 other select", {31'b0, conv_req}, 0);
    bus_write(12'h014, 32'h0);

    // R7 completion and clear in the same cycle
    bus_write(12'h0A4, 32'h6);
    bus_write(12'h028, 32'h8);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h00C; wdata = 32'h8; conv_done = 1'b1; conv_result = 12'h055;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; conv_done = 1'b0;
    bus_read(12'h004, d); check("R7 set wins", d, 32'h8);
    bus_write(12'h00C, 32'h8);
    bus_read(12'h004, d); check("R7 clear after", d, 0);
    bus_read(12'h0A8, d); check("R8 same-cycle result", d, 32'h055);

    summary();
  end
endmodule